// File: doc/BRIEF.md
# Dual-Latency Crossing Readout Pipeline

This block keeps the hit words of every bunch crossing in a circular store and sends the same crossing out twice. The first copy goes to the fast tracking trigger when an early pre-trigger names it. The second copy goes to data acquisition when the final accept names it. A separate short-latency tap always shows the hit count and first hit of a recent crossing, for local coincidence with a paired layer.

A crossing strobe marks the start of each crossing. Hit words arrive with a valid flag between strobes. A single trigger line, sampled on the strobe cycle, carries both kinds of request. The block tells them apart by the age of the crossing each one points to. Requests wait in a small queue. The output is a word stream in which each frame is a header, then the hits, then a trailer, with a tag on every word.

Top module: `dual_tap_readout`

## Requirements
- R1: Each cycle with `bx_i` high starts a new crossing. Crossings are numbered modulo 2^CNT_W, and the first strobe after reset starts crossing 0. A hit presented in the same cycle as `bx_i` belongs to the new crossing.
- R2: A crossing stores up to MAX_HITS hit words in arrival order. Any later hit for that crossing is dropped and sets the crossing's overflow mark.
- R3: `trig_i` is only sampled when `bx_i` is high, and it is judged against the crossing n that this strobe starts. If crossing n-ACC_LAT carries a pending pre-trigger mark, the request is a final accept for that crossing.
- R4: In every other case, a sampled trigger is a pre-trigger for crossing n-PRE_LAT and places a pending mark on it. When an accept and a pre-trigger would both apply on the same strobe, the accept wins.
- R5: A pending mark is withdrawn on the strobe that brings its crossing to age ACC_LAT, whether or not a trigger is present. An unconfirmed crossing therefore never turns a later trigger into an accept.
- R6: A frame is built from the following words:
  - Header, tag 1: bit HIT_W-1 is 1 for an accept and 0 for a pre-trigger, and the low CNT_W bits hold the crossing number.
  - Stored hits, tag 0, in arrival order.
  - Trailer, tag 2: bit HIT_W-1 holds the overflow mark, and the low bits hold the stored count.
- R7: Frames come out in request order. Within a frame there is one word per cycle with no gap, and `out_valid_o` is low after each trailer and whenever nothing is being sent.
- R8: In every cycle, `tap_cnt_o` gives the stored count of crossing (current - TAP_LAT). `tap_hit_o` gives that crossing's first hit, or zero when the count is zero.
- R9: During and right after reset, `out_valid_o` is low and both tap outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_i | input | 1 | Start-of-crossing strobe |
| hit_valid_i | input | 1 | Hit word valid |
| hit_i | input | HIT_W | Hit word |
| trig_i | input | 1 | Shared pre-trigger / accept line, sampled with bx_i |
| out_valid_o | output | 1 | Output word valid |
| out_tag_o | output | 2 | 0 hit, 1 header, 2 trailer |
| out_word_o | output | HIT_W | Output word |
| tap_cnt_o | output | $clog2(MAX_HITS+1) | Hit count of crossing current-TAP_LAT |
| tap_hit_o | output | HIT_W | First hit of that crossing, or zero |

## Verification
The bench builds the block with a 64-slot store (CNT_W=6), PRE_LAT=16, ACC_LAT=40, TAP_LAT=3 and MAX_HITS=3, and uses eight clocks per crossing. With these sizes, counter wrap, the first crossings that point at never-written slots, and many accept-after-pre pairs all occur within a few hundred crossings. Some crossings carry four hits, which drives the store into overflow. In a long stretch where the trigger line is high on every strobe, the accept-over-pre-trigger priority and the withdrawal of unconfirmed marks both come up.

// File: rtl/drp_pkg.sv
package drp_pkg;
  typedef enum logic [1:0] {
    TAG_HIT = 2'd0,
    TAG_HDR = 2'd1,
    TAG_TRL = 2'd2
  } tag_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HDR,
    S_HIT,
    S_TRL
  } emit_st_e;
endpackage

// File: rtl/bx_store.sv
module bx_store #(
  parameter int CNT_W    = 10,
  parameter int HIT_W    = 16,
  parameter int MAX_HITS = 2,
  parameter int PRE_LAT  = 256,
  parameter int ACC_LAT  = 512,
  parameter int TAP_LAT  = 80,
  localparam int CW      = $clog2(MAX_HITS + 1),
  localparam int IW      = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bx_i,
  input  logic             hit_valid_i,
  input  logic [HIT_W-1:0] hit_i,
  input  logic             trig_i,
  output logic             req_valid_o,
  output logic             req_acc_o,
  output logic [CNT_W-1:0] req_bx_o,
  input  logic [CNT_W-1:0] rd_bx_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [CW-1:0]    rd_cnt_o,
  output logic             rd_ovf_o,
  output logic [HIT_W-1:0] rd_hit_o,
  output logic [CW-1:0]    tap_cnt_o,
  output logic [HIT_W-1:0] tap_hit_o
);
  localparam int DEPTH = 1 << CNT_W;
  localparam logic [CNT_W-1:0] PRE_OFS = CNT_W'(PRE_LAT);
  localparam logic [CNT_W-1:0] ACC_OFS = CNT_W'(ACC_LAT);
  localparam logic [CNT_W-1:0] TAP_OFS = CNT_W'(TAP_LAT);
  localparam logic [CW-1:0]    MAX_C   = CW'(MAX_HITS);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, wr_slot, pre_slot, acc_slot, tap_slot;
  logic [CW-1:0]    cnt_arr [DEPTH];
  logic [HIT_W-1:0] mem     [DEPTH][MAX_HITS];
  logic [DEPTH-1:0] ovf_arr, pend_arr;
  logic [CW-1:0]    base;
  logic             room;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign wr_slot  = bx_i ? cnt_nxt : cnt_q;
  assign pre_slot = cnt_nxt - PRE_OFS;
  assign acc_slot = cnt_nxt - ACC_OFS;
  assign tap_slot = cnt_q - TAP_OFS;
  // a strobe empties the slot it opens
  assign base     = bx_i ? '0 : cnt_arr[cnt_q];
  assign room     = base < MAX_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '1;
      ovf_arr  <= '0;
      pend_arr <= '0;
      for (int i = 0; i < DEPTH; i++) cnt_arr[i] <= '0;
    end else begin
      if (bx_i) begin
        cnt_q            <= cnt_nxt;
        cnt_arr[cnt_nxt] <= '0;
        ovf_arr[cnt_nxt] <= 1'b0;
        pend_arr[acc_slot] <= 1'b0;
        if (trig_i && !pend_arr[acc_slot]) pend_arr[pre_slot] <= 1'b1;
      end
      if (hit_valid_i) begin
        if (room) cnt_arr[wr_slot] <= base + 1'b1;
        else      ovf_arr[wr_slot] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (hit_valid_i && room) mem[wr_slot][base[IW-1:0]] <= hit_i;
  end

  assign req_valid_o = bx_i && trig_i;
  assign req_acc_o   = pend_arr[acc_slot];
  assign req_bx_o    = pend_arr[acc_slot] ? acc_slot : pre_slot;

  assign rd_cnt_o  = cnt_arr[rd_bx_i];
  assign rd_ovf_o  = ovf_arr[rd_bx_i];
  assign rd_hit_o  = mem[rd_bx_i][rd_idx_i];
  assign tap_cnt_o = cnt_arr[tap_slot];
  assign tap_hit_o = (cnt_arr[tap_slot] != '0) ? mem[tap_slot][0] : '0;

  // R1
  bx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R1
  bx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_i |=> $stable(cnt_q));
  // R2
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && !bx_i && cnt_arr[cnt_q] == MAX_C) |=>
      (ovf_arr[cnt_q] && cnt_arr[cnt_q] == MAX_C));
  // R5
  pend_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_i |=> !pend_arr[$past(acc_slot)]);
endmodule

// File: rtl/req_fifo.sv
module req_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam logic [AW:0]   FULL_C = (AW + 1)'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   fill_q;
  logic          push_ok, pop_ok;

  // a request arriving on a full queue is lost
  assign push_ok = push_i && (fill_q != FULL_C);
  assign pop_ok  = pop_i && (fill_q != '0);
  assign empty_o = (fill_q == '0);
  assign data_o  = slot_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == LAST_C) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == LAST_C) ? '0 : rp_q + 1'b1;
      fill_q <= fill_q + (push_ok ? 1'b1 : 1'b0) - (pop_ok ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) slot_q[wp_q] <= data_i;
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FULL_C);
  // R7
  pop_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> fill_q != '0);
endmodule

// File: rtl/frame_emit.sv
module frame_emit
  import drp_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int HIT_W    = 16,
  parameter int MAX_HITS = 2,
  localparam int CW      = $clog2(MAX_HITS + 1),
  localparam int IW      = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             empty_i,
  input  logic             head_acc_i,
  input  logic [CNT_W-1:0] head_bx_i,
  output logic             pop_o,
  output logic [CNT_W-1:0] rd_bx_o,
  output logic [IW-1:0]    rd_idx_o,
  input  logic [CW-1:0]    rd_cnt_i,
  input  logic             rd_ovf_i,
  input  logic [HIT_W-1:0] rd_hit_i,
  output logic             out_valid_o,
  output logic [1:0]       out_tag_o,
  output logic [HIT_W-1:0] out_word_o
);
  emit_st_e         st_q;
  tag_e             tag;
  logic             acc_q;
  logic [CNT_W-1:0] bx_q;
  logic [CW-1:0]    idx_q;

  assign pop_o    = (st_q == S_IDLE) && !empty_i;
  assign rd_bx_o  = bx_q;
  assign rd_idx_o = idx_q[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      acc_q <= 1'b0;
      bx_q  <= '0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (!empty_i) begin
          acc_q <= head_acc_i;
          bx_q  <= head_bx_i;
          st_q  <= S_HDR;
        end
        S_HDR: begin
          idx_q <= '0;
          st_q  <= (rd_cnt_i == '0) ? S_TRL : S_HIT;
        end
        S_HIT: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q + 1'b1 == rd_cnt_i) st_q <= S_TRL;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    out_word_o = '0;
    tag        = TAG_HIT;
    unique case (st_q)
      S_HDR: begin
        tag                    = TAG_HDR;
        out_word_o[HIT_W-1]    = acc_q;
        out_word_o[CNT_W-1:0]  = bx_q;
      end
      S_HIT: out_word_o = rd_hit_i;
      S_TRL: begin
        tag                   = TAG_TRL;
        out_word_o[HIT_W-1]   = rd_ovf_i;
        out_word_o[CW-1:0]    = rd_cnt_i;
      end
      default: ;
    endcase
  end

  assign out_valid_o = (st_q != S_IDLE);
  assign out_tag_o   = tag;

  // R7
  hdr_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && tag == TAG_HDR) |=> out_valid_o);
  // R7
  trl_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && tag == TAG_TRL) |=> !out_valid_o);
endmodule

// File: rtl/dual_tap_readout.sv
module dual_tap_readout #(
  parameter int CNT_W    = 10,
  parameter int HIT_W    = 16,
  parameter int MAX_HITS = 2,
  parameter int PRE_LAT  = 256,
  parameter int ACC_LAT  = 512,
  parameter int TAP_LAT  = 80,
  parameter int QDEPTH   = 4,
  localparam int CW      = $clog2(MAX_HITS + 1),
  localparam int IW      = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bx_i,
  input  logic             hit_valid_i,
  input  logic [HIT_W-1:0] hit_i,
  input  logic             trig_i,
  output logic             out_valid_o,
  output logic [1:0]       out_tag_o,
  output logic [HIT_W-1:0] out_word_o,
  output logic [CW-1:0]    tap_cnt_o,
  output logic [HIT_W-1:0] tap_hit_o
);
  logic             req_valid, req_acc, head_acc, pop, empty;
  logic [CNT_W-1:0] req_bx, head_bx, rd_bx;
  logic [IW-1:0]    rd_idx;
  logic [CW-1:0]    rd_cnt;
  logic             rd_ovf;
  logic [HIT_W-1:0] rd_hit;

  bx_store #(
    .CNT_W(CNT_W), .HIT_W(HIT_W), .MAX_HITS(MAX_HITS),
    .PRE_LAT(PRE_LAT), .ACC_LAT(ACC_LAT), .TAP_LAT(TAP_LAT)
  ) u_store (
    .clk_i, .rst_ni, .bx_i, .hit_valid_i, .hit_i, .trig_i,
    .req_valid_o(req_valid), .req_acc_o(req_acc), .req_bx_o(req_bx),
    .rd_bx_i(rd_bx), .rd_idx_i(rd_idx),
    .rd_cnt_o(rd_cnt), .rd_ovf_o(rd_ovf), .rd_hit_o(rd_hit),
    .tap_cnt_o, .tap_hit_o
  );

  req_fifo #(.W(CNT_W + 1), .DEPTH(QDEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(req_valid), .data_i({req_acc, req_bx}),
    .pop_i(pop), .data_o({head_acc, head_bx}), .empty_o(empty)
  );

  frame_emit #(.CNT_W(CNT_W), .HIT_W(HIT_W), .MAX_HITS(MAX_HITS)) u_emit (
    .clk_i, .rst_ni,
    .empty_i(empty), .head_acc_i(head_acc), .head_bx_i(head_bx), .pop_o(pop),
    .rd_bx_o(rd_bx), .rd_idx_o(rd_idx),
    .rd_cnt_i(rd_cnt), .rd_ovf_i(rd_ovf), .rd_hit_i(rd_hit),
    .out_valid_o, .out_tag_o, .out_word_o
  );
endmodule

// File: tb/dual_tap_readout_test.sv
module dual_tap_readout_test;
  localparam int CLK_P    = 10;
  localparam int CNT_W    = 6;
  localparam int HIT_W    = 16;
  localparam int MAX_HITS = 3;
  localparam int PRE_LAT  = 16;
  localparam int ACC_LAT  = 40;
  localparam int TAP_LAT  = 3;
  localparam int BXP      = 8;
  localparam int DEPTH    = 1 << CNT_W;
  localparam int CW       = $clog2(MAX_HITS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bx = 1'b0, hv = 1'b0, trig = 1'b0;
  logic [HIT_W-1:0] hit = '0;
  logic out_valid;
  logic [1:0] out_tag;
  logic [HIT_W-1:0] out_word, tap_hit;
  logic [CW-1:0] tap_cnt;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [HIT_W-1:0] m_hits [DEPTH][$];
  bit m_ovf [DEPTH];
  bit m_pend [DEPTH];
  int m_cur;
  logic [HIT_W+1:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  dual_tap_readout #(
    .CNT_W(CNT_W), .HIT_W(HIT_W), .MAX_HITS(MAX_HITS),
    .PRE_LAT(PRE_LAT), .ACC_LAT(ACC_LAT), .TAP_LAT(TAP_LAT), .QDEPTH(4)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .bx_i(bx), .hit_valid_i(hv), .hit_i(hit),
    .trig_i(trig), .out_valid_o(out_valid), .out_tag_o(out_tag),
    .out_word_o(out_word), .tap_cnt_o(tap_cnt), .tap_hit_o(tap_hit)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_frame(bit acc, int slot);
    logic [HIT_W-1:0] w;
    w = '0; w[HIT_W-1] = acc; w[CNT_W-1:0] = CNT_W'(slot);
    exp_q.push_back({2'd1, w});
    foreach (m_hits[slot][k]) exp_q.push_back({2'd0, m_hits[slot][k]});
    w = '0; w[HIT_W-1] = m_ovf[slot]; w[CW-1:0] = CW'(m_hits[slot].size());
    exp_q.push_back({2'd2, w});
  endtask

  // compare outputs against the model, then drive one cycle
  task automatic cyc(bit b, bit t, bit v);
    int ts;
    logic [HIT_W+1:0] e;
    @(negedge clk);
    ts = (m_cur - TAP_LAT + DEPTH) % DEPTH;
    chk(tap_cnt == CW'(m_hits[ts].size()), "R8 tap count", tap_cnt, m_hits[ts].size());
    e[HIT_W-1:0] = (m_hits[ts].size() != 0) ? m_hits[ts][0] : '0;
    chk(tap_hit == e[HIT_W-1:0], "R8 tap hit", tap_hit, e[HIT_W-1:0]);
    if (out_valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected word", {out_tag, out_word}, 0);
      else begin
        e = exp_q.pop_front();
        if (e[HIT_W+1:HIT_W] == 2'd1)
          chk({out_tag, out_word} == e, "R1 R3 R4 R5 R6 header", {out_tag, out_word}, e);
        else if (e[HIT_W+1:HIT_W] == 2'd0)
          chk({out_tag, out_word} == e, "R2 R6 hit word", {out_tag, out_word}, e);
        else
          chk({out_tag, out_word} == e, "R2 R6 trailer", {out_tag, out_word}, e);
      end
    end
    bx = b; trig = t; hv = v; hit = $urandom();
    if (b) begin
      int acc_s, pre_s;
      bit was;
      m_cur = (m_cur + 1) % DEPTH;
      m_hits[m_cur].delete();
      m_ovf[m_cur] = 0;
      acc_s = (m_cur - ACC_LAT + DEPTH) % DEPTH;
      pre_s = (m_cur - PRE_LAT + DEPTH) % DEPTH;
      was = m_pend[acc_s];
      m_pend[acc_s] = 0;
      if (t) begin
        if (was) push_frame(1'b1, acc_s);
        else begin push_frame(1'b0, pre_s); m_pend[pre_s] = 1; end
      end
    end
    if (v) begin
      if (m_hits[m_cur].size() < MAX_HITS) m_hits[m_cur].push_back(hit);
      else m_ovf[m_cur] = 1;
    end
  endtask

  task automatic crossing(int n_hits, bit t);
    for (int k = 0; k < BXP; k++) cyc(k == 0, (k == 0) && t, k < n_hits);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R7 watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cur = DEPTH - 1;
    for (int i = 0; i < DEPTH; i++) begin m_ovf[i] = 0; m_pend[i] = 0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    chk(tap_cnt == '0, "R9 reset tap count", tap_cnt, 0);
    chk(tap_hit == '0, "R9 reset tap hit", tap_hit, 0);
    rst_n = 1'b1;
    // mixed pattern: hit counts 0..4 (4 overflows), sparse triggers
    for (int x = 0; x < 150; x++) crossing((x * 7 + 3) % 5, (x % 3 == 1) || (x % 5 == 0));
    // trigger on every strobe: accept priority and mark expiry
    for (int x = 0; x < 70; x++) crossing(x % 5, 1'b1);
    // drain
    for (int x = 0; x < 6; x++) crossing(x % 3, 1'b0);
    chk(exp_q.size() == 0, "R7 frames outstanding", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule